// File: doc/BRIEF.md
# Masked Raster-Operation Word Datapath

This block is the word engine between a host bus and the video memory of a one-bit-per-pixel frame buffer. Every host access to memory becomes a fixed read-modify-write of one 16-bit word. On a write access the host word passes through three stages. First, a funnel shifter runs only in block-transfer mode. Second, a source selector picks the word. Third, a 4-bit raster operation combines source S and destination D. A per-bit write-protect mask then merges the result into the destination. A read access returns the memory word to the host. In block-transfer mode a read also primes the shift holding register, so bits that cross a word boundary are ready for the first real word of a row. Software uses this priming read when the destination bit offset is below the source bit offset in an ascending transfer, and the mirrored case in a descending one.

A small register file holds the setup. One register holds the mode and shift amount. One is a control byte that enables the raster op and drives the display, sync and blit-type outputs. The others are the source select, the raster-op word and the write mask. A command port resets the register file and blanks or unblanks the display.

The controller has four states. S_IDLE goes to S_READ when a request arrives. S_READ strobes `mem_rd` and goes to S_CAPTURE. S_CAPTURE latches the destination word. From S_CAPTURE the controller goes to S_WRITE for a write access, or back to S_IDLE for a read access. S_WRITE strobes `mem_wr` and returns to S_IDLE.

Top module: `rop_blit_path`

## Requirements
- R1: A request accepted in S_IDLE raises `busy` on the next cycle. `mem_rd` is high for exactly that one cycle. For a write access, `mem_wr` is high for exactly one cycle, two cycles after `mem_rd`. `busy` falls in the cycle after the last strobe.
- R2: After reset, `busy`, `mem_rd`, `mem_wr`, `disp_on`, `sync_en`, `sync_rst_n` and `addr_blit` are all 0. The mode is normal, the source select is full word, the raster op is disabled and the mask is 0.
- R3: When the raster op is enabled, the written word is f(S,D), where f is selected by the code: 0:0, 1:S&D, 2:S&~D, 3:S, 4:~S&D, 5:D, 6:S^D, 7:S|D, 8:~(S|D), 9:~(S^D), A:~D, B:S|~D, C:~S, D:~S|D, E:~(S&D), F:all ones.
- R4: A 1 in the mask register (select 4) keeps that bit of the destination read from memory. A 0 takes the computed bit. A mask of 0 writes the whole word.
- R5: Bit 4 of the control byte (select 1) enables the raster op. When the bit is 0, the written word is the selected source.
- R6: Bits 7:6 of the source-select byte (select 2) choose the source. 00 gives all ones. 01 copies bit 0 of the data word to all 16 bits. 11 (and 10) gives the full data word.
- R7: The mode/shift byte (select 0) holds the mode in bits 7:5 and the shift in bits 4:0. In block-transfer mode (100), the data word is ({hold, data} >> (shift mod 16))[15:0]. A write then loads hold with its host data.
- R8: A read access returns the memory word on `host_rdata` once `busy` falls. In block-transfer mode the read also loads hold with that word.
- R9: In normal mode (111) and vector mode (010), the shift is bypassed and the host data is used unchanged.
- R10: A write of 0x80 to the command port (select 5) restores every register to its reset value. Command bit 0 unblanks the display when 1 and blanks it when 0. `disp_on` is unblank AND control bit 0.
- R11: The raster-op word (select 3) is stored as it appears on the bus, which is byte-swapped. The active code is therefore bus bits 11:8, and bits 3:0 have no effect.
- R12: Control bit 7 drives `addr_blit`, bit 1 drives `sync_en` and bit 3 drives `sync_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 mode/shift, 1 control, 2 source, 3 raster op, 4 mask, 5 command) |
| cfg_wdata | input | 16 | Register write data |
| acc_req | input | 1 | Memory access request, taken in S_IDLE |
| acc_is_write | input | 1 | 1 = read-modify-write, 0 = read |
| acc_addr | input | AW | Word address |
| acc_wdata | input | 16 | Host data word |
| busy | output | 1 | Access in progress |
| host_rdata | output | 16 | Word returned by a read access |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_rdata | input | 16 | Memory read data, valid one cycle after `mem_rd` |
| mem_wdata | output | 16 | Memory write data |
| disp_on | output | 1 | Display enabled |
| sync_en | output | 1 | Sync enable |
| sync_rst_n | output | 1 | Sync reset, active low |
| addr_blit | output | 1 | Address-blit (1) or pixel-blit (0) |

## Verification
The assertions check the strobe discipline of R1 on every cycle: a read strobe lasts one cycle, a write strobe always follows a read by two cycles, and both strobes occur only while busy. They also check on every cycle that masked bits of every written word equal the destination read just before (R4), and that a reset command restores the mode and mask (R10). The raster-op table, source selection, funnel shift across a word boundary, byte-swapped code position and the mode bypass can only be shown by the bench. The bench drives known source and destination words and compares every memory write against an independently computed value.

// File: rtl/rop_blit_pkg.sv
package rop_blit_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_READ    = 2'd1,
        S_CAPTURE = 2'd2,
        S_WRITE   = 2'd3
    } acc_state_e;

    localparam logic [2:0] MODE_VEC  = 3'b010;
    localparam logic [2:0] MODE_BLT  = 3'b100;
    localparam logic [2:0] MODE_NORM = 3'b111;

    localparam logic [2:0] SEL_MODE = 3'd0;
    localparam logic [2:0] SEL_CTL  = 3'd1;
    localparam logic [2:0] SEL_SRC  = 3'd2;
    localparam logic [2:0] SEL_ROP  = 3'd3;
    localparam logic [2:0] SEL_MASK = 3'd4;
    localparam logic [2:0] SEL_CMD  = 3'd5;

    function automatic logic [15:0] rop_apply(input logic [3:0] code,
                                              input logic [15:0] s,
                                              input logic [15:0] d);
        logic [15:0] r;
        unique case (code)
            4'h0: r = 16'h0000;
            4'h1: r = s & d;
            4'h2: r = s & ~d;
            4'h3: r = s;
            4'h4: r = ~s & d;
            4'h5: r = d;
            4'h6: r = s ^ d;
            4'h7: r = s | d;
            4'h8: r = ~(s | d);
            4'h9: r = ~(s ^ d);
            4'hA: r = ~d;
            4'hB: r = s | ~d;
            4'hC: r = ~s;
            4'hD: r = ~s | d;
            4'hE: r = ~(s & d);
            4'hF: r = 16'hFFFF;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/rop_cfg_regs.sv
module rop_cfg_regs
    import rop_blit_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    output logic [2:0]    mode,
    output logic [4:0]    shamt,
    output logic [7:0]    ctl,
    output logic [1:0]    src_sel,
    output logic [3:0]    rop_code,
    output logic [DW-1:0] wmask,
    output logic          unblank
);
    logic [7:0]    mode_q, ctl_q, src_q;
    logic [DW-1:0] rop_q, mask_q;
    logic          unblank_q;
    logic          cmd_reset;

    assign cmd_reset = cfg_wr && (cfg_sel == SEL_CMD) && (cfg_wdata[7:0] == 8'h80);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= {MODE_NORM, 5'd0};
            ctl_q     <= 8'h00;
            src_q     <= 8'hC0;
            rop_q     <= 16'h0300;
            mask_q    <= '0;
            unblank_q <= 1'b0;
        end else if (cmd_reset) begin
            mode_q    <= {MODE_NORM, 5'd0};
            ctl_q     <= 8'h00;
            src_q     <= 8'hC0;
            rop_q     <= 16'h0300;
            mask_q    <= '0;
            unblank_q <= 1'b0;
        end else if (cfg_wr) begin
            unique case (cfg_sel)
                SEL_MODE: mode_q    <= cfg_wdata[7:0];
                SEL_CTL:  ctl_q     <= cfg_wdata[7:0];
                SEL_SRC:  src_q     <= cfg_wdata[7:0];
                SEL_ROP:  rop_q     <= cfg_wdata;
                SEL_MASK: mask_q    <= cfg_wdata;
                SEL_CMD:  unblank_q <= cfg_wdata[0];
                default:  ;
            endcase
        end
    end

    assign mode     = mode_q[7:5];
    assign shamt    = mode_q[4:0];
    assign ctl      = ctl_q;
    assign src_sel  = src_q[7:6];
    assign rop_code = rop_q[11:8];
    assign wmask    = mask_q;
    assign unblank  = unblank_q;

    p_cmd_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (mode == MODE_NORM && wmask == '0 && ctl == 8'h00 && !unblank));
endmodule

// File: rtl/rop_word_core.sv
module rop_word_core
    import rop_blit_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [2:0]    mode,
    input  logic [4:0]    shamt,
    input  logic [1:0]    src_sel,
    input  logic          rop_en,
    input  logic [3:0]    rop_code,
    input  logic [DW-1:0] wmask,
    input  logic [DW-1:0] host_word,
    input  logic [DW-1:0] hold_word,
    input  logic [DW-1:0] dest_word,
    output logic [DW-1:0] out_word
);
    localparam int SW = $clog2(DW);

    logic [2*DW-1:0] funnel;
    logic [DW-1:0]   data_w, src_w, rop_w;

    always_comb begin
        funnel = {hold_word, host_word} >> shamt[SW-1:0];
        data_w = (mode == MODE_BLT) ? funnel[DW-1:0] : host_word;
        unique case (src_sel)
            2'b00:   src_w = '1;
            2'b01:   src_w = {DW{data_w[0]}};
            default: src_w = data_w;
        endcase
        rop_w    = rop_en ? rop_apply(rop_code, src_w, dest_word) : src_w;
        out_word = (wmask & dest_word) | (~wmask & rop_w);
    end
endmodule

// File: rtl/rop_blit_path.sv
module rop_blit_path
    import rop_blit_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          acc_req,
    input  logic          acc_is_write,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic          busy,
    output logic [DW-1:0] host_rdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    output logic          disp_on,
    output logic          sync_en,
    output logic          sync_rst_n,
    output logic          addr_blit
);
    acc_state_e    state_q, state_d;
    logic          is_wr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q, dest_q, hold_q, rdata_q;

    logic [2:0]    mode;
    logic [4:0]    shamt;
    logic [7:0]    ctl;
    logic [1:0]    src_sel;
    logic [3:0]    rop_code;
    logic [DW-1:0] wmask;
    logic          unblank;

    rop_cfg_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mode(mode), .shamt(shamt), .ctl(ctl),
        .src_sel(src_sel), .rop_code(rop_code), .wmask(wmask), .unblank(unblank)
    );

    rop_word_core #(.DW(DW)) u_core (
        .mode(mode), .shamt(shamt), .src_sel(src_sel), .rop_en(ctl[4]),
        .rop_code(rop_code), .wmask(wmask), .host_word(data_q),
        .hold_word(hold_q), .dest_word(dest_q), .out_word(mem_wdata)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (acc_req) state_d = S_READ;
            S_READ:    state_d = S_CAPTURE;
            S_CAPTURE: state_d = is_wr_q ? S_WRITE : S_IDLE;
            S_WRITE:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_wr_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            dest_q  <= '0;
            hold_q  <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (acc_req) begin
                    is_wr_q <= acc_is_write;
                    addr_q  <= acc_addr;
                    data_q  <= acc_wdata;
                end
                S_CAPTURE: begin
                    dest_q <= mem_rdata;
                    if (!is_wr_q) begin
                        rdata_q <= mem_rdata;
                        if (mode == MODE_BLT) hold_q <= mem_rdata;
                    end
                end
                S_WRITE: if (mode == MODE_BLT) hold_q <= data_q;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != S_IDLE);
        mem_rd     = (state_q == S_READ);
        mem_wr     = (state_q == S_WRITE);
        mem_addr   = addr_q;
        host_rdata = rdata_q;
        disp_on    = unblank & ctl[0];
        sync_en    = ctl[1];
        sync_rst_n = ctl[3];
        addr_blit  = ctl[7];
    end

    p_rd_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    p_wr_after_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd, 2));
    p_strobe_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> busy);
    p_no_rd_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    p_mask_keeps_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (((mem_wdata ^ $past(mem_rdata)) & wmask) == '0));
endmodule

// File: tb/rop_blit_path_bench.sv
module rop_blit_path_bench;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic acc_req = 1'b0, acc_is_write = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic busy, mem_rd, mem_wr, disp_on, sync_en, sync_rst_n, addr_blit;
    logic [15:0] host_rdata, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem [0:255];

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    logic [AW-1:0] adr_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    rop_blit_path #(.AW(AW)) u_rop_blit_path (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_req(acc_req), .acc_is_write(acc_is_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .busy(busy),
        .host_rdata(host_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .disp_on(disp_on), .sync_en(sync_en), .sync_rst_n(sync_rst_n),
        .addr_blit(addr_blit)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    function automatic logic [15:0] ref_rop(input logic [3:0] c, input logic [15:0] s, input logic [15:0] d);
        case (c)
            4'h0: return 16'h0000;   4'h1: return s & d;
            4'h2: return s & ~d;     4'h3: return s;
            4'h4: return ~s & d;     4'h5: return d;
            4'h6: return s ^ d;      4'h7: return s | d;
            4'h8: return ~(s | d);   4'h9: return ~(s ^ d);
            4'hA: return ~d;         4'hB: return s | ~d;
            4'hC: return ~s;         4'hD: return ~s | d;
            4'hE: return ~(s & d);   default: return 16'hFFFF;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected writes from the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_wr) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R1: actual write %h at %h expected no write", mem_wdata, mem_addr);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic logic [AW-1:0] a = adr_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (mem_wdata !== e || mem_addr !== a) begin
                    errors++;
                    $display("FAIL %s: actual %h@%h expected %h@%h", t, mem_wdata, mem_addr, e, a);
                end
            end
        end
    end

    task automatic cfg(input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic rmw(input string tag, input logic [AW-1:0] a, input logic [15:0] d,
                       input logic [15:0] s, input logic [15:0] exp, input bit timing);
        mem[a] = d;
        exp_q.push_back(exp); adr_q.push_back(a); tag_q.push_back(tag);
        @(negedge clk); acc_req = 1'b1; acc_is_write = 1'b1; acc_addr = a; acc_wdata = s;
        @(negedge clk); acc_req = 1'b0;
        if (timing) check("R1 read strobe+busy", {14'd0, busy, mem_rd}, 16'h0003);
        @(negedge clk);
        if (timing) check("R1 gap cycle", {14'd0, mem_wr, mem_rd}, 16'h0000);
        @(negedge clk);
        if (timing) check("R1 write strobe", {14'd0, busy, mem_wr}, 16'h0003);
        @(negedge clk);
        if (timing) check("R1 busy falls", {15'd0, busy}, 16'h0000);
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a, input logic [15:0] d);
        mem[a] = d;
        @(negedge clk); acc_req = 1'b1; acc_is_write = 1'b0; acc_addr = a;
        @(negedge clk); acc_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(tag, {busy, host_rdata[14:0]}, {1'b0, d[14:0]});
        check(tag, host_rdata, d);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R2 reset state
        check("R2 outputs", {9'd0, busy, mem_rd, mem_wr, disp_on, sync_en, sync_rst_n, addr_blit}, 16'h0000);
        rst_n = 1'b1;
        // R1 timing, R2/R5 defaults: raster op off, full word, mask 0
        rmw("R5 rop off passes source", 8'd1, 16'h1234, 16'hABCD, 16'hABCD, 1'b1);
        // R3 + R11 all codes (code in bus bits 11:8)
        cfg(3'd1, 16'h0010);
        for (int c = 0; c < 16; c++) begin
            cfg(3'd3, {4'h0, c[3:0], 8'h00});
            rmw("R3 rop code", 8'd2, 16'hF0F0, 16'hCCCC, ref_rop(c[3:0], 16'hCCCC, 16'hF0F0), 1'b0);
        end
        // R11 low nibble has no effect: active code 0
        cfg(3'd3, 16'h0006);
        rmw("R11 swapped nibble", 8'd3, 16'h5555, 16'hCCCC, 16'h0000, 1'b0);
        cfg(3'd3, 16'h0300);
        // R4 mask
        cfg(3'd4, 16'hFF00);
        rmw("R4 mask protects", 8'd4, 16'h1234, 16'hABCD, 16'h12CD, 1'b0);
        cfg(3'd4, 16'h0000);
        rmw("R4 mask zero", 8'd4, 16'h1234, 16'hABCD, 16'hABCD, 1'b0);
        // R6 source select
        cfg(3'd2, 16'h0000);
        rmw("R6 all ones", 8'd5, 16'h0000, 16'h1234, 16'hFFFF, 1'b0);
        cfg(3'd2, 16'h0040);
        rmw("R6 replicate 1", 8'd5, 16'h0000, 16'h0001, 16'hFFFF, 1'b0);
        rmw("R6 replicate 0", 8'd5, 16'h1111, 16'hFFFE, 16'h0000, 1'b0);
        cfg(3'd2, 16'h0080);
        rmw("R6 select 10 full", 8'd5, 16'h0000, 16'h1234, 16'h1234, 1'b0);
        cfg(3'd2, 16'h00C0);
        // R7/R8 block transfer with priming read
        cfg(3'd0, 16'h0084);
        rd("R8 priming read", 8'd10, 16'h1234);
        rmw("R7 funnel first", 8'd11, 16'h0000, 16'hABCD, 16'h4ABC, 1'b0);
        rmw("R7 funnel carry", 8'd12, 16'h0000, 16'h5678, 16'hD567, 1'b0);
        cfg(3'd0, 16'h0094);
        rmw("R7 shift mod 16", 8'd13, 16'h0000, 16'h9ABC, 16'h89AB, 1'b0);
        cfg(3'd0, 16'h0080);
        rmw("R7 shift zero", 8'd14, 16'h0000, 16'h1357, 16'h1357, 1'b0);
        // R9 bypass
        cfg(3'd0, 16'h00E5);
        rmw("R9 normal bypass", 8'd15, 16'h0000, 16'h2468, 16'h2468, 1'b0);
        cfg(3'd0, 16'h0045);
        rmw("R9 vector bypass", 8'd15, 16'h0000, 16'h2468, 16'h2468, 1'b0);
        rd("R8 read in normal path", 8'd16, 16'hBEEF);
        // R12 control outputs, R10 unblank/blank
        cfg(3'd1, 16'h008B);
        @(negedge clk);
        check("R12 ctl outputs", {13'd0, addr_blit, sync_en, sync_rst_n}, 16'h0007);
        check("R10 still blanked", {15'd0, disp_on}, 16'h0000);
        cfg(3'd5, 16'h0001);
        @(negedge clk);
        check("R10 unblank", {15'd0, disp_on}, 16'h0001);
        cfg(3'd5, 16'h0000);
        @(negedge clk);
        check("R10 blank", {15'd0, disp_on}, 16'h0000);
        // R10 command reset
        cfg(3'd5, 16'h0001);
        cfg(3'd4, 16'hFFFF);
        cfg(3'd0, 16'h0084);
        cfg(3'd5, 16'h0080);
        @(negedge clk);
        check("R10 reset outputs", {12'd0, disp_on, addr_blit, sync_en, sync_rst_n}, 16'h0000);
        rmw("R10 mask and mode restored", 8'd20, 16'h0F0F, 16'h7777, 16'h7777, 1'b0);
        repeat (3) @(negedge clk);
        check("R1 scoreboard drained", 16'(exp_q.size()), 16'h0000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule